// File: doc/BRIEF.md
# Shift Register with J/K-not Serial Entry and Output Polarity Select

This block is an N-stage clocked register that works in one of two modes, picked by a mode input. In load mode every stage captures its own bit of a parallel data bus on the rising clock edge. In shift mode the stages form a chain: each later stage takes the value the stage before it held just before the edge. The first stage takes a value worked out from a J input, a K-not input and its own current bit. That entry rule can force a 0, force a 1, hold or toggle. When J and K-not are tied together it acts as a plain D input. This makes the block useful for counters, sequence generators and serial/parallel conversion.

The outputs pass through a polarity stage that does not depend on the clock. With the polarity input high they show the stored bits; with it low they show the inverted bits. An active-low reset clears every stage at once, whatever the clock is doing. The release of that reset is synchronised to the clock, so the register only starts to update on the third rising edge after the reset input goes high.

Top module: `jk_shift_register`

## Requirements
- R1: With `par_mode` high (load mode), every stage k takes `par_data[k]` at the rising edge; stage 1 is bit 0.
- R2: With `par_mode` low (shift mode), stage k+1 takes the value stage k held before the edge, and all stages update on the same edge.
- R3: In shift mode with `j_in` equal to `kn_in`, stage 1 takes that common value (00 gives 0, 11 gives 1).
- R4: In shift mode with `j_in`=0 and `kn_in`=1, stage 1 keeps its value.
- R5: In shift mode with `j_in`=1 and `kn_in`=0, stage 1 inverts its value.
- R6: `q_out` equals the stored bits when `true_out` is 1 and their inverse when `true_out` is 0, and a change of `true_out` shows at `q_out` between clock edges, with no edge.
- R7: `rst_n` low clears all stages at once, without a clock edge, and keeps them cleared whatever the mode, J/K-not or parallel inputs are.
- R8: After `rst_n` rises, the first two rising edges leave the register cleared; the register updates from the third edge on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; state changes on its rising edge |
| rst_n | input | 1 | Active-low reset; asserts asynchronously, releases synchronously |
| par_mode | input | 1 | 1 = parallel load, 0 = shift with J/K-not entry |
| j_in | input | 1 | J input of the first-stage entry logic |
| kn_in | input | 1 | K-not input of the first-stage entry logic |
| par_data | input | N | Parallel data; bit k feeds stage k+1 |
| true_out | input | 1 | Output polarity: 1 = stored bits, 0 = inverted bits |
| q_out | output | N | Register contents after the polarity stage |

## Verification
The clocked assertions assume that `par_mode`, `j_in`, `kn_in` and `par_data` are stable around each rising edge. They also assume that `rst_n` is driven to a known level before the first edge. The stimulus meets this by changing these inputs only on the falling clock edge. `rst_n` starts high and falls one time unit into the run. The polarity input and the reset are moved a few time units after a falling edge. This checks their clock-independent effect while the edge-sampled inputs stay settled.

// File: rtl/jsr_pkg.sv
package jsr_pkg;
  typedef enum logic {
    SHIFT_MODE = 1'b0,
    LOAD_MODE  = 1'b1
  } jsr_mode_e;

  localparam int MIN_STAGES = 2;
endpackage

// File: rtl/jsr_rst_sync.sv
module jsr_rst_sync #(
  parameter int SYNC_DEPTH = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [SYNC_DEPTH-1:0] sync_q;
  logic [SYNC_DEPTH-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[SYNC_DEPTH-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[SYNC_DEPTH-1];

  // R8
  release_hold_chk: assert property (@(posedge clk) !rst_n |=> !rst_sync_n)
    else $error("synchronised reset released one edge after raw reset was low");
endmodule

// File: rtl/jsr_entry.sv
module jsr_entry (
  input  logic cur_bit,
  input  logic j_in,
  input  logic kn_in,
  output logic next_bit
);
  always_comb begin
    unique case ({j_in, kn_in})
      2'b00:   next_bit = 1'b0;
      2'b11:   next_bit = 1'b1;
      2'b01:   next_bit = cur_bit;
      default: next_bit = ~cur_bit;
    endcase
  end
endmodule

// File: rtl/jsr_chain.sv
module jsr_chain
  import jsr_pkg::*;
#(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_sync_n,
  input  jsr_mode_e    mode,
  input  logic         entry_bit,
  input  logic         j_in,
  input  logic         kn_in,
  input  logic [N-1:0] par_data,
  output logic [N-1:0] state_q
);
  localparam int LAST = N - 1;

  logic [N-1:0] stage_d;
  logic [N-1:0] stage_en;
  logic         load_sel;

  assign load_sel = (mode == LOAD_MODE);

  for (genvar g = 0; g < N; g++) begin : g_stage
    if (g == 0) begin : g_head
      always_comb stage_d[g] = load_sel ? par_data[g] : entry_bit;
    end else begin : g_body
      always_comb stage_d[g] = load_sel ? par_data[g] : state_q[g-1];
    end
    always_comb stage_en[g] = stage_d[g] ^ state_q[g];

    always_ff @(posedge clk or negedge rst_sync_n) begin
      if (!rst_sync_n)       state_q[g] <= 1'b0;
      else if (stage_en[g])  state_q[g] <= stage_d[g];
    end
  end

  // R1
  load_capture_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    mode == LOAD_MODE |=> state_q == $past(par_data))
    else $error("parallel load mismatch");

  // R2
  shift_chain_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    mode == SHIFT_MODE |=> state_q[LAST:1] == $past(state_q[LAST-1:0]))
    else $error("shift chain mismatch");

  // R3
  jk_force_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mode == SHIFT_MODE && j_in == kn_in) |=> state_q[0] == $past(j_in))
    else $error("first stage did not follow tied J/K-not");

  // R4
  jk_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mode == SHIFT_MODE && !j_in && kn_in) |=> $stable(state_q[0]))
    else $error("first stage did not hold");

  // R5
  jk_toggle_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mode == SHIFT_MODE && j_in && !kn_in) |=> state_q[0] != $past(state_q[0]))
    else $error("first stage did not toggle");

  // R7
  clear_hold_chk: assert property (@(posedge clk) !rst_sync_n |-> state_q == '0)
    else $error("register not cleared during reset");
endmodule

// File: rtl/jsr_polarity.sv
module jsr_polarity #(
  parameter int N = 4
) (
  input  logic         true_sel,
  input  logic [N-1:0] data_in,
  output logic [N-1:0] data_out
);
  logic [N-1:0] flip_mask;

  always_comb begin
    flip_mask = {N{~true_sel}};
    data_out  = data_in ^ flip_mask;
  end
endmodule

// File: rtl/jk_shift_register.sv
module jk_shift_register
  import jsr_pkg::*;
#(
  parameter int N          = 4,
  parameter int SYNC_DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         par_mode,
  input  logic         j_in,
  input  logic         kn_in,
  input  logic [N-1:0] par_data,
  input  logic         true_out,
  output logic [N-1:0] q_out
);
  logic         rst_sync_n;
  logic [N-1:0] state_q;
  logic         entry_bit;
  jsr_mode_e    mode;

  assign mode = par_mode ? LOAD_MODE : SHIFT_MODE;

  jsr_rst_sync #(.SYNC_DEPTH(SYNC_DEPTH)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  jsr_entry u_entry (
    .cur_bit  (state_q[0]),
    .j_in     (j_in),
    .kn_in    (kn_in),
    .next_bit (entry_bit)
  );

  jsr_chain #(.N(N)) u_chain (
    .clk        (clk),
    .rst_sync_n (rst_sync_n),
    .mode       (mode),
    .entry_bit  (entry_bit),
    .j_in       (j_in),
    .kn_in      (kn_in),
    .par_data   (par_data),
    .state_q    (state_q)
  );

  jsr_polarity #(.N(N)) u_polarity (
    .true_sel (true_out),
    .data_in  (state_q),
    .data_out (q_out)
  );

  // R6
  polarity_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (true_out != $past(true_out)) && $stable(state_q) |-> q_out == ~$past(q_out))
    else $error("polarity change did not invert outputs");
endmodule

// File: tb/jk_shift_register_bench.sv
module jk_shift_register_bench;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b1;
  logic         par_mode = 1'b1;
  logic         j_in = 1'b0;
  logic         kn_in = 1'b0;
  logic [N-1:0] par_data = '0;
  logic         true_out = 1'b1;
  logic [N-1:0] q_out;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [N-1:0] m_reg = '0;
  int           m_rel = 0;
  string        m_tag = "R7";
  bit           m_serial = 1'b0;
  logic         m_first;

  always #5 clk = ~clk;

  jk_shift_register #(.N(N)) u_jk_shift_register (
    .clk      (clk),
    .rst_n    (rst_n),
    .par_mode (par_mode),
    .j_in     (j_in),
    .kn_in    (kn_in),
    .par_data (par_data),
    .true_out (true_out),
    .q_out    (q_out)
  );

  // behavioural reference: stage 1 = bit 0, release takes two edges
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_reg = '0; m_rel = 0; m_tag = "R7"; m_serial = 1'b0;
    end else if (m_rel < 2) begin
      m_rel = m_rel + 1; m_tag = "R8"; m_serial = 1'b0;
    end else if (par_mode) begin
      m_reg = par_data; m_tag = "R1"; m_serial = 1'b0;
    end else begin
      if (j_in == kn_in) begin m_first = j_in; m_tag = "R3"; end
      else if (kn_in)    begin m_first = m_reg[0]; m_tag = "R4"; end
      else               begin m_first = ~m_reg[0]; m_tag = "R5"; end
      m_reg = {m_reg[N-2:0], m_first};
      m_serial = 1'b1;
    end
  end

  function automatic logic [N-1:0] expect_q();
    return true_out ? m_reg : ~m_reg;
  endfunction

  task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_now();
    logic [N-1:0] low_mask;
    low_mask = {{(N-1){1'b0}}, 1'b1};
    if (m_serial) begin
      chk(m_tag, q_out & low_mask, expect_q() & low_mask);
      chk("R2", q_out & ~low_mask, expect_q() & ~low_mask);
    end else begin
      chk(m_tag, q_out, expect_q());
    end
  endtask

  task automatic step(input logic md, input logic jj, input logic kk, input logic [N-1:0] pd);
    @(negedge clk);
    compare_now();
    par_mode = md; j_in = jj; kn_in = kk; par_data = pd;
  endtask

  task automatic pol_flip();
    @(negedge clk);
    compare_now();
    #2 true_out = ~true_out;
    #1 chk("R6", q_out, expect_q());
  endtask

  task automatic reset_mid();
    @(negedge clk);
    compare_now();
    par_mode = 1'b1; par_data = '1; j_in = 1'b1; kn_in = 1'b0;
    #2 rst_n = 1'b0;
    #1 chk("R7", q_out, expect_q());
    chk("R7", q_out, true_out ? '0 : '1);
  endtask

  task automatic release_mid();
    @(negedge clk);
    compare_now();
    #2 rst_n = 1'b1;
  endtask

  initial begin
    #1 rst_n = 1'b0;
    @(negedge clk);
    chk("R7", q_out, '0);
    repeat (2) step(1'b1, 1'b1, 1'b0, 4'hF);
    repeat (2) step(1'b0, 1'b1, 1'b0, 4'hF);
    release_mid();
    par_mode = 1'b1; par_data = 4'hA;
    repeat (3) step(1'b1, 1'b0, 1'b0, 4'hA);
    // parallel patterns
    for (int i = 0; i < 6; i++) begin
      logic [N-1:0] pats [6];
      pats = '{4'h5, 4'h3, 4'hC, 4'hF, 4'h0, 4'h9};
      step(1'b1, 1'b0, 1'b0, pats[i]);
    end
    step(1'b1, 1'b0, 1'b0, 4'h0);
    // all J/K-not cases, serial
    for (int i = 0; i < 20; i++) begin
      step(1'b0, i[0], i[1] ^ i[2], 4'h6);
    end
    // toggle and hold runs
    repeat (5) step(1'b0, 1'b1, 1'b0, 4'h0);
    repeat (3) step(1'b0, 1'b0, 1'b1, 4'h0);
    // tied J/K-not as D input
    for (int i = 0; i < 8; i++) begin
      logic dbit;
      dbit = (i % 3) == 0;
      step(1'b0, dbit, dbit, 4'hF);
    end
    // mode switching
    for (int i = 0; i < 10; i++) begin
      step(i[0], i[1], i[2], 4'(i * 5 + 3));
    end
    // polarity changes between edges
    step(1'b0, 1'b1, 1'b0, 4'h0);
    repeat (4) pol_flip();
    step(1'b1, 1'b0, 1'b0, 4'hB);
    pol_flip();
    pol_flip();
    // reset mid-cycle, then release
    step(1'b0, 1'b1, 1'b1, 4'h0);
    reset_mid();
    repeat (2) step(1'b1, 1'b1, 1'b0, 4'hF);
    pol_flip();
    pol_flip();
    release_mid();
    par_mode = 1'b0; j_in = 1'b1; kn_in = 1'b0;
    repeat (6) step(1'b0, 1'b1, 1'b0, 4'h7);
    step(1'b1, 1'b0, 1'b0, 4'hD);
    step(1'b0, 1'b0, 1'b1, 4'h0);
    @(negedge clk);
    compare_now();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule